// File: doc/BRIEF.md
# Implicit-Length String Lane Tagger and Result Formatter

This block sits at both ends of a packed string-compare datapath. On the way in, it looks at two 128-bit operands, each holding either sixteen byte elements or eight 16-bit word elements. For each operand it finds the lowest-indexed element that is all zeros, which acts as the terminator. It then marks every element below that terminator as valid and every other element as invalid. The two valid vectors go straight out, without a register, to an external compare and aggregation stage.

That stage returns an intermediate result vector. The block turns the vector into a 128-bit destination value and six status flags. The destination takes one of two forms: a zero-extended bit vector, or a mask in which each result bit fills a whole lane. The flags report whether the result is nonzero, whether either operand held a terminator, and what result bit 0 is. The remaining two flags are always clear.

The formatted result and the flags are registered. A two-state controller (ST_IDLE, ST_EMIT) raises the output strobe one cycle after each accepted input. It has three transitions:
- T_ACCEPT: ST_IDLE goes to ST_EMIT when in_valid is high.
- T_CHAIN: ST_EMIT stays in ST_EMIT when in_valid is high.
- T_DRAIN: ST_EMIT returns to ST_IDLE when in_valid is low.

Top module: `strm_mask_unit`

## Requirements
- R1: ctrl[0] selects the element size: 0 gives 16 byte lanes (lane i = bits 8i+7:8i), 1 gives 8 word lanes (lane j = bits 16j+15:16j).
- R2: a_valid / b_valid bit i is 1 exactly when lane i is below the lowest all-zero lane of op_a / op_b. With no zero lane, all active lanes are valid. In word mode, bits 15:8 are 0.
- R3: With ctrl[6]=0, out_data is the effective result, zero-extended to 128 bits. The effective result is int_res in byte mode and int_res[7:0] in word mode.
- R4: With ctrl[6]=1, each effective result bit i fills lane i of out_data with all ones when set and all zeros when clear. In word mode the lanes are 16 bits wide and int_res[15:8] is ignored.
- R5: out_flags[0] (carry) is 1 exactly when the effective result is nonzero.
- R6: out_flags[1] (zero) is 1 exactly when op_b contains an all-zero element of the selected size.
- R7: out_flags[2] (sign) is 1 exactly when op_a contains an all-zero element of the selected size.
- R8: out_flags[3] (overflow) equals bit 0 of the effective result.
- R9: out_flags[4] (auxiliary carry) and out_flags[5] (parity) are always 0.
- R10: out_valid is high in the cycle after in_valid is high and low in the cycle after in_valid is low. out_data and out_flags reflect the inputs of that accepted cycle.
- R11: While reset is asserted, out_valid, out_data and out_flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept this cycle's operands and result |
| ctrl | input | 8 | Control byte: bit 0 element size, bit 6 output format |
| op_a | input | 128 | First string operand |
| op_b | input | 128 | Second string operand |
| int_res | input | 16 | Intermediate result from the aggregation stage |
| a_valid | output | 16 | Lane valid vector for op_a (combinational) |
| b_valid | output | 16 | Lane valid vector for op_b (combinational) |
| out_valid | output | 1 | Registered result strobe |
| out_data | output | 128 | Registered destination value |
| out_flags | output | 6 | Registered flags {parity, aux, overflow, sign, zero, carry} |

## Verification
The valid vectors have no register, so they are due in the same cycle as the operands. The bench reads them a short delay after driving the inputs at the falling edge. Destination, flags and strobe pass through one register, so they are due one cycle after the accepted input. The bench reads them at the next falling edge, before it drives further stimulus. Back-to-back inputs and a cycle with in_valid low check that the strobe follows in_valid with exactly that one-cycle lag.

// File: rtl/strm_pkg.sv
package strm_pkg;
    parameter int ELEM_W   = 8;
    parameter int LANES    = 16;
    parameter int OP_W     = ELEM_W * LANES;
    parameter int WLANES   = LANES / 2;
    parameter int WELEM_W  = ELEM_W * 2;
    parameter int CTRL_W   = 8;
    parameter int FLAG_W   = 6;
    parameter int CTL_SIZE = 0;
    parameter int CTL_FMT  = 6;
    parameter int FL_CARRY = 0;
    parameter int FL_ZERO  = 1;
    parameter int FL_SIGN  = 2;
    parameter int FL_OVFL  = 3;
    parameter int FL_AUX   = 4;
    parameter int FL_PAR   = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } strm_state_e;
endpackage

// File: rtl/strm_lane_tagger.sv
module strm_lane_tagger
    import strm_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic             word_mode,
    output logic [LANES-1:0] valid,
    output logic             any_null
);
    logic [LANES-1:0]  null_b;
    logic [WLANES-1:0] null_w;
    logic [LANES-1:0]  null_sel;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_bnull
            assign null_b[gi] = (op[gi*ELEM_W +: ELEM_W] == '0);
        end
        for (gi = 0; gi < WLANES; gi++) begin : g_wnull
            assign null_w[gi] = (op[gi*WELEM_W +: WELEM_W] == '0);
        end
    endgenerate

    always_comb begin
        if (word_mode) null_sel = {{(LANES-WLANES){1'b0}}, null_w};
        else           null_sel = null_b;
    end

    assign any_null = |null_sel;

    // prefix scan: a lane stays valid until a terminator has been seen
    always_comb begin
        logic seen;
        seen  = 1'b0;
        valid = '0;
        for (int i = 0; i < LANES; i++) begin
            seen = seen | null_sel[i];
            valid[i] = !seen && (!word_mode || (i < WLANES));
        end
    end
endmodule

// File: rtl/strm_result_fmt.sv
module strm_result_fmt
    import strm_pkg::*;
(
    input  logic [LANES-1:0] res,
    input  logic             word_mode,
    input  logic             mask_mode,
    output logic [LANES-1:0] eff_res,
    output logic [OP_W-1:0]  data
);
    always_comb begin
        if (word_mode) eff_res = {{(LANES-WLANES){1'b0}}, res[WLANES-1:0]};
        else           eff_res = res;
    end

    always_comb begin
        data = '0;
        if (!mask_mode) begin
            data[LANES-1:0] = eff_res;
        end else if (word_mode) begin
            for (int j = 0; j < WLANES; j++)
                data[j*WELEM_W +: WELEM_W] = {WELEM_W{eff_res[j]}};
        end else begin
            for (int i = 0; i < LANES; i++)
                data[i*ELEM_W +: ELEM_W] = {ELEM_W{eff_res[i]}};
        end
    end
endmodule

// File: rtl/strm_flag_gen.sv
module strm_flag_gen
    import strm_pkg::*;
(
    input  logic [LANES-1:0]  eff_res,
    input  logic              a_null,
    input  logic              b_null,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags           = '0;
        flags[FL_CARRY] = |eff_res;
        flags[FL_ZERO]  = b_null;
        flags[FL_SIGN]  = a_null;
        flags[FL_OVFL]  = eff_res[0];
        flags[FL_AUX]   = 1'b0;
        flags[FL_PAR]   = 1'b0;
    end
endmodule

// File: rtl/strm_mask_unit.sv
module strm_mask_unit
    import strm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [LANES-1:0]  int_res,
    output logic [LANES-1:0]  a_valid,
    output logic [LANES-1:0]  b_valid,
    output logic              out_valid,
    output logic [OP_W-1:0]   out_data,
    output logic [FLAG_W-1:0] out_flags
);
    logic word_mode;
    logic mask_mode;
    logic [1:0] null_any;
    logic [LANES-1:0] valid_v [2];
    logic [OP_W-1:0]  op_v [2];
    logic [LANES-1:0] eff_res;
    logic [OP_W-1:0]  data_d;
    logic [FLAG_W-1:0] flags_d;

    strm_state_e state_q, state_d;

    assign word_mode = ctrl[CTL_SIZE];
    assign mask_mode = ctrl[CTL_FMT];
    assign op_v[0] = op_a;
    assign op_v[1] = op_b;

    genvar gk;
    generate
        for (gk = 0; gk < 2; gk++) begin : g_tag
            strm_lane_tagger u_tag (
                .op        (op_v[gk]),
                .word_mode (word_mode),
                .valid     (valid_v[gk]),
                .any_null  (null_any[gk])
            );
        end
    endgenerate

    assign a_valid = valid_v[0];
    assign b_valid = valid_v[1];

    strm_result_fmt u_fmt (
        .res       (int_res),
        .word_mode (word_mode),
        .mask_mode (mask_mode),
        .eff_res   (eff_res),
        .data      (data_d)
    );

    strm_flag_gen u_flags (
        .eff_res (eff_res),
        .a_null  (null_any[0]),
        .b_null  (null_any[1]),
        .flags   (flags_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_flags <= '0;
        end else if (in_valid) begin
            out_data  <= data_d;
            out_flags <= flags_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_AUX_PAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_flags[FL_AUX] == 1'b0 && out_flags[FL_PAR] == 1'b0)); // R9
    AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_flags[FL_CARRY] == (|out_data))); // R5
    AST_OVFL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_flags[FL_OVFL] == out_data[0])); // R8
    AST_VALID_PREFIX_A: assert property (@(posedge clk) disable iff (!rst_n) ((a_valid + 1'b1) & a_valid) == '0); // R2
    AST_VALID_PREFIX_B: assert property (@(posedge clk) disable iff (!rst_n) ((b_valid + 1'b1) & b_valid) == '0); // R2
    AST_WORD_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n) word_mode |-> (a_valid[LANES-1:WLANES] == '0 && b_valid[LANES-1:WLANES] == '0)); // R2
endmodule

// File: tb/strm_mask_unit_tb_top.sv
module strm_mask_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [7:0]   ctrl;
    logic [127:0] op_a, op_b;
    logic [15:0]  int_res;
    logic [15:0]  a_valid, b_valid;
    logic         out_valid;
    logic [127:0] out_data;
    logic [5:0]   out_flags;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    strm_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
        .op_a(op_a), .op_b(op_b), .int_res(int_res),
        .a_valid(a_valid), .b_valid(b_valid), .out_valid(out_valid),
        .out_data(out_data), .out_flags(out_flags)
    );

    function automatic logic [15:0] exp_valid(logic [127:0] op, logic word);
        logic [15:0] v = '0;
        int n = word ? 8 : 16;
        for (int i = 0; i < n; i++) begin
            logic z = word ? (op[i*16 +: 16] == 0) : (op[i*8 +: 8] == 0);
            if (z) break;
            v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic has_null(logic [127:0] op, logic word);
        int n = word ? 8 : 16;
        for (int i = 0; i < n; i++)
            if (word ? (op[i*16 +: 16] == 0) : (op[i*8 +: 8] == 0)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [15:0] eres(logic [15:0] r, logic word);
        return word ? {8'h00, r[7:0]} : r;
    endfunction

    function automatic logic [127:0] exp_data(logic [7:0] c, logic [15:0] r);
        logic [15:0] e = eres(r, c[0]);
        logic [127:0] d = '0;
        if (!c[6]) d[15:0] = e;
        else if (c[0]) for (int j = 0; j < 8; j++) d[j*16 +: 16] = {16{e[j]}};
        else for (int i = 0; i < 16; i++) d[i*8 +: 8] = {8{e[i]}};
        return d;
    endfunction

    function automatic logic [5:0] exp_flags(logic [7:0] c, logic [127:0] a,
                                             logic [127:0] b, logic [15:0] r);
        logic [15:0] e = eres(r, c[0]);
        return {1'b0, 1'b0, e[0], has_null(a, c[0]), has_null(b, c[0]), |e};
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge; valids now, registered results one cycle later
    task automatic apply(logic [7:0] c, logic [127:0] a, logic [127:0] b, logic [15:0] r);
        ctrl = c; op_a = a; op_b = b; int_res = r; in_valid = 1'b1;
        #1;
        chk("R1/R2 a_valid", 128'(a_valid), 128'(exp_valid(a, c[0])));
        chk("R1/R2 b_valid", 128'(b_valid), 128'(exp_valid(b, c[0])));
        @(negedge clk);
        chk("R10 out_valid", 128'(out_valid), 128'(1));
        chk(c[6] ? "R4 out_data mask" : "R3 out_data bits", out_data, exp_data(c, r));
        chk("R5-R9 flags (R5 R6 R7 R8 R9)", 128'(out_flags), 128'(exp_flags(c, a, b, r)));
    endtask

    function automatic logic [127:0] rnd_op();
        logic [127:0] v;
        for (int i = 0; i < 16; i++)
            v[i*8 +: 8] = ($urandom_range(0, 5) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R10: got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; in_valid = 1'b0; ctrl = '0; op_a = '0; op_b = '0; int_res = '0;
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", 128'(out_valid), 128'(0));
        chk("R11 reset out_data", out_data, 128'(0));
        chk("R11 reset out_flags", 128'(out_flags), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        apply(8'h00, {16{8'h41}}, {16{8'h42}}, 16'h0000);          // R2 no null, R5 zero result
        apply(8'h40, 128'h0, {{15{8'h33}}, 8'h00}, 16'hA5A5);      // R2 null at lane 0, R4 byte mask
        apply(8'h00, {8'h00, {15{8'h11}}}, {16{8'h22}}, 16'h8001); // R2 null in last lane, R8
        apply(8'h01, {{14{8'h55}}, 8'h00, 8'h77}, {16{8'h66}}, 16'hFF02); // R1 word: high byte zero only
        apply(8'h41, {{12{8'h10}}, 32'h0000_1234}, {16{8'h01}}, 16'h3C81); // R4 word mask, upper res ignored
        apply(8'h01, {16{8'h09}}, {{8{8'h09}}, 64'h0}, 16'hFF00);  // R3 word, R5 effective zero
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle out_valid", 128'(out_valid), 128'(0));

        // random, back-to-back
        for (int n = 0; n < 300; n++) begin
            logic [7:0] c = 8'($urandom());
            apply(c, rnd_op(), rnd_op(), 16'($urandom()));
            if ($urandom_range(0, 3) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk("R10 gap out_valid", 128'(out_valid), 128'(0));
            end
        end

        in_valid = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule